// File: doc/BRIEF.md
# Block Fill Controller with Selectable Memory Organization

This block services a cache miss by fetching one whole cache line of four words from a modelled main memory and handing it back to the cache. A fill starts when the cache raises a request with a word address while the controller is ready. The controller aligns that address down to the line boundary, spends one cycle sending it, waits out the bank access time with internal counters and then returns the line in ascending word order. A one-cycle done pulse marks the end of the fill. No external memory model is needed: the bank contents are a fixed function of the word address.

A parameter selects one of four memory organizations, each with its exact cycle cost. A one-word-wide memory runs four serialized accesses, each followed by a one-word transfer. Two-word and four-word-wide memories run two accesses or one, each followed by a one-cycle beat that carries two or four words. In the interleaved organization the four words of the line sit in four banks (bank = word address mod 4). All four banks start together on the address cycle, so their accesses overlap and only the four one-word transfers are serialized.

The response bus is as wide as one memory beat. That is one word for the narrow and interleaved organizations, and two or four words for the wide ones.

Top module: `blkfill_ctrl`

## Requirements
- R1: After reset, fill_ready is 1 and rsp_valid and fill_done are 0 until a request is accepted.
- R2: A request is accepted in a cycle where fill_req and fill_ready are both 1; that cycle counts as cycle 1 (the address cycle). Every bank access lasts 15 cycles, so the first response beat of every organization appears in cycle 17.
- R3: With the one-word-wide organization (ORG=0), words come one per beat after each of four serialized accesses, and the last beat is in cycle 65 = 1 + 4×15 + 4×1.
- R4: With the two-word-wide organization (ORG=1), each beat carries two words, and the last beat is in cycle 33. In every organization, word k of a beat occupies rsp_data bits [32k+31:32k], and rsp_idx is the index of word 0 of that beat within the line.
- R5: With the four-word-wide organization (ORG=2), the whole line comes in one beat with rsp_idx 0 in cycle 17.
- R6: With the interleaved organization (ORG=3, the default), the four words come on four consecutive cycles, 17 to 20. Each word is read from bank (word address mod 4).
- R7: Beats come in ascending rsp_idx order starting at 0. The two low bits of fill_addr are ignored, so the line base is fill_addr with bits [1:0] cleared.
- R8: The data word for word address a is the low 32 bits of (a × 40503) XOR 0x0F0F9669.
- R9: fill_ready is 0 from the cycle after acceptance through the done cycle. A request held during a fill is ignored: it does not restart or alter the fill in progress.
- R10: fill_done is 1 for exactly one cycle, the cycle after the last beat. fill_ready returns to 1 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_req | input | 1 | Line fill request |
| fill_addr | input | AW | Word address of the missing word |
| fill_ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | A response beat is on rsp_data |
| rsp_idx | output | 2 | Line index of the first word in the beat |
| rsp_data | output | beat words × WORD_W | Beat data, word k at bits [WORD_W·k +: WORD_W] |
| fill_done | output | 1 | One-cycle end-of-fill pulse |

## Verification
The bench drives the request at a falling edge and treats the rising edge that follows as the end of cycle 1. It then samples every output at each later falling edge, with a running cycle number. Every beat is checked against its expected cycle: the first beat in cycle 17, the last beat in cycle 65, 33, 17 or 20 depending on organization, and fill_done exactly one cycle after the last beat. fill_ready is tracked over the whole span from cycle 2 to the done cycle. One cycle after done, the bench confirms that ready is back and no beat is on the bus. Index and data of each beat are compared with values computed from the aligned address.

// File: rtl/blkfill_pkg.sv
// Shared constants and the modelled memory content for the block fill
// controller. Assumes word addresses of at most 64 bits.
package blkfill_pkg;

    localparam int ORG_NARROW = 0;  // one word wide, serialized accesses
    localparam int ORG_DUAL   = 1;  // two words wide
    localparam int ORG_QUAD   = 2;  // four words wide
    localparam int ORG_INTLV  = 3;  // word-interleaved banks

    // Content of the modelled memory at a word address
    function automatic logic [63:0] word_pat(input logic [63:0] a);
        return (a * 64'd40503) ^ 64'h5A5A_C3C3_0F0F_9669;
    endfunction

endpackage

// File: rtl/blkfill_bank.sv
// One memory bank: latches an address on start, counts out LAT access
// cycles, then captures BW consecutive words and holds them until the
// next start. Assumes LAT >= 1 and no start while an access is running.
module blkfill_bank #(
    parameter int WORD_W = 32,
    parameter int AW     = 16,
    parameter int BW     = 1,
    parameter int LAT    = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        addr,
    output logic                 fin,
    output logic [BW*WORD_W-1:0] data
);
    import blkfill_pkg::*;

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]        cnt;
    logic [AW-1:0]        addr_q;
    logic [BW*WORD_W-1:0] rd_words;

    // Model the array read for the latched address
    always_comb begin
        for (int k = 0; k < BW; k++) begin
            rd_words[k*WORD_W +: WORD_W] = WORD_W'(word_pat(64'(addr_q) + 64'(k)));
        end
    end

    // Access timer, address latch and output capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            addr_q <= '0;
            data   <= '0;
        end else if (start) begin
            cnt    <= CW'(LAT);
            addr_q <= addr;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                data <= rd_words;
            end
        end
    end

    assign fin = (cnt == CW'(1));

    // The sequencer must never restart a bank in the middle of an access
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> !start);

    // An access finishes once, then the bank goes quiet
    assert_fin_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/blkfill_seq.sv
// Fill sequencer: accepts a request, starts groups of bank accesses,
// steps through the transfer beats of each group and ends with a done
// cycle. Assumes all banks of a group finish in the same cycle.
module blkfill_seq #(
    parameter int AW   = 16,
    parameter int BLK  = 4,
    parameter int BW   = 1,
    parameter int NGRP = 4,
    parameter int BPG  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic [AW-1:0]           req_addr,
    input  logic                    all_fin,
    output logic                    ready,
    output logic                    start,
    output logic [AW-1:0]           st_addr,
    output logic                    xfer,
    output logic [$clog2(BLK)-1:0]  idx,
    output logic [(BPG > 1 ? $clog2(BPG) : 1)-1:0] beat,
    output logic                    done
);
    localparam int IDXW   = $clog2(BLK);
    localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int BEAT_W = (BPG > 1) ? $clog2(BPG) : 1;

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_DONE} st_t;

    st_t             state;
    logic [GRP_W-1:0] grp;
    logic [AW-1:0]   base;
    logic            beat_last;
    logic            grp_last;
    logic [AW-1:0]   req_base;

    assign req_base  = req_addr & ~AW'(BLK - 1);
    assign beat_last = (beat == BEAT_W'(BPG - 1));
    assign grp_last  = (grp == GRP_W'(NGRP - 1));

    // Control outputs decoded from the state
    always_comb begin
        ready   = (state == S_IDLE);
        xfer    = (state == S_XFER);
        done    = (state == S_DONE);
        start   = (ready && req) || (xfer && beat_last && !grp_last);
        st_addr = ready ? req_base
                        : base + AW'((int'(grp) + 1) * BW);
        idx     = IDXW'(int'(grp) * BW + int'(beat));
    end

    // State, group and beat counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            grp   <= '0;
            beat  <= '0;
            base  <= '0;
        end else begin
            case (state)
                S_IDLE: if (req) begin
                    base  <= req_base;
                    grp   <= '0;
                    state <= S_WAIT;
                end
                S_WAIT: if (all_fin) begin
                    beat  <= '0;
                    state <= S_XFER;
                end
                S_XFER: if (beat_last) begin
                    if (grp_last) begin
                        state <= S_DONE;
                    end else begin
                        grp   <= grp + 1'b1;
                        state <= S_WAIT;
                    end
                end else begin
                    beat <= beat + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Once accepted, a fill keeps the controller busy in the next cycle
    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

endmodule

// File: rtl/blkfill_ctrl.sv
// Block fill controller top. Picks the memory organization from ORG,
// builds the banks it needs and routes the current beat to the response
// bus. Assumes BLK_WORDS = 4 for the wide and interleaved layouts.
module blkfill_ctrl #(
    parameter int ORG       = blkfill_pkg::ORG_INTLV,
    parameter int WORD_W    = 32,
    parameter int AW        = 16,
    parameter int BLK_WORDS = 4,
    parameter int ACC_LAT   = 15,
    localparam int BW = (ORG == blkfill_pkg::ORG_DUAL) ? 2 :
                        (ORG == blkfill_pkg::ORG_QUAD) ? BLK_WORDS : 1,
    localparam int IDXW = $clog2(BLK_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_req,
    input  logic [AW-1:0]        fill_addr,
    output logic                 fill_ready,
    output logic                 rsp_valid,
    output logic [IDXW-1:0]      rsp_idx,
    output logic [BW*WORD_W-1:0] rsp_data,
    output logic                 fill_done
);
    import blkfill_pkg::*;

    localparam bit INTLV  = (ORG == ORG_INTLV);
    localparam int NBANK  = INTLV ? BLK_WORDS : 1;
    localparam int NGRP   = INTLV ? 1 : BLK_WORDS / BW;
    localparam int BPG    = INTLV ? BLK_WORDS : 1;
    localparam int BEAT_W = (BPG > 1) ? $clog2(BPG) : 1;
    localparam int LAST_IDX = BLK_WORDS - BW;

    logic                 start;
    logic [AW-1:0]        st_addr;
    logic [BEAT_W-1:0]    beat;
    logic [NBANK-1:0]     fin;
    logic [BW*WORD_W-1:0] bank_data [NBANK];

    blkfill_seq #(
        .AW(AW), .BLK(BLK_WORDS), .BW(BW), .NGRP(NGRP), .BPG(BPG)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req(fill_req), .req_addr(fill_addr), .all_fin(&fin),
        .ready(fill_ready), .start(start), .st_addr(st_addr),
        .xfer(rsp_valid), .idx(rsp_idx), .beat(beat), .done(fill_done)
    );

    // One bank per interleave way; bank i always holds word i of the line
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        blkfill_bank #(
            .WORD_W(WORD_W), .AW(AW), .BW(BW), .LAT(ACC_LAT)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .start(start),
            .addr(st_addr + AW'(i)), .fin(fin[i]), .data(bank_data[i])
        );
    end

    // Route the bank that owns the current beat to the response bus
    if (INTLV) begin : g_sel_intlv
        assign rsp_data = bank_data[beat];
    end else begin : g_sel_wide
        assign rsp_data = bank_data[0];
        logic unused_beat;
        assign unused_beat = ^beat;
    end

    // Expected next index, kept for the ordering check
    logic [IDXW:0] chk_next;
    always_ff @(posedge clk) begin
        if (!rst_n || fill_done) begin
            chk_next <= '0;
        end else if (rsp_valid) begin
            chk_next <= (IDXW+1)'(rsp_idx) + (IDXW+1)'(BW);
        end
    end

    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_idx == chk_next[IDXW-1:0]));

    assert_busy_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || fill_done) |-> !fill_ready);

    assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_idx == IDXW'(LAST_IDX)) |=> fill_done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (!fill_done && fill_ready));

endmodule

// File: tb/sim_blkfill_ctrl.sv
`timescale 1ns/1ps
// Directed bench: one instance per memory organization, one task per scenario.
module sim_blkfill_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Index 0 interleaved, 1 one-word, 2 two-word, 3 four-word
    logic         req_v   [4];
    logic [15:0]  addr_v  [4];
    logic         ready_v [4];
    logic         valid_v [4];
    logic [1:0]   idx_v   [4];
    logic         done_v  [4];
    logic [127:0] data_v  [4];

    logic [31:0]  d0, d1;
    logic [63:0]  d2;
    logic [127:0] d3;

    blkfill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fill_req(req_v[0]), .fill_addr(addr_v[0]),
        .fill_ready(ready_v[0]), .rsp_valid(valid_v[0]), .rsp_idx(idx_v[0]),
        .rsp_data(d0), .fill_done(done_v[0]));
    blkfill_ctrl #(.ORG(0)) u1 (
        .clk(clk), .rst_n(rst_n), .fill_req(req_v[1]), .fill_addr(addr_v[1]),
        .fill_ready(ready_v[1]), .rsp_valid(valid_v[1]), .rsp_idx(idx_v[1]),
        .rsp_data(d1), .fill_done(done_v[1]));
    blkfill_ctrl #(.ORG(1)) u2 (
        .clk(clk), .rst_n(rst_n), .fill_req(req_v[2]), .fill_addr(addr_v[2]),
        .fill_ready(ready_v[2]), .rsp_valid(valid_v[2]), .rsp_idx(idx_v[2]),
        .rsp_data(d2), .fill_done(done_v[2]));
    blkfill_ctrl #(.ORG(2)) u3 (
        .clk(clk), .rst_n(rst_n), .fill_req(req_v[3]), .fill_addr(addr_v[3]),
        .fill_ready(ready_v[3]), .rsp_valid(valid_v[3]), .rsp_idx(idx_v[3]),
        .rsp_data(d3), .fill_done(done_v[3]));

    assign data_v[0] = {96'b0, d0};
    assign data_v[1] = {96'b0, d1};
    assign data_v[2] = {64'b0, d2};
    assign data_v[3] = d3;

    // Expected memory word (R8)
    function automatic logic [31:0] ref_word(input logic [15:0] a);
        logic [63:0] p;
        p = {48'b0, a} * 64'd40503;
        return p[31:0] ^ 32'h0F0F_9669;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int words_of(input int o);
        return (o == 2) ? 2 : (o == 3) ? 4 : 1;
    endfunction

    // Run one fill on instance o and check every beat, its cycle and the end
    task automatic run_fill(input int o, input logic [15:0] a, input int lat,
                            input bit hold, input string rq);
        int bw = words_of(o);
        logic [15:0] base = {a[15:2], 2'b00};
        int c = 2;
        int nexp = 0;
        bit seen_done = 0;
        bit ready_bad = 0;
        @(negedge clk);
        chk(ready_v[o] == 1'b1, "R1", "ready before fill", 128'(ready_v[o]), 128'd1);
        req_v[o]  = 1'b1;
        addr_v[o] = a;
        @(posedge clk);
        @(negedge clk);
        if (!hold) req_v[o] = 1'b0;
        addr_v[o] = 16'hFFFF;
        while (!seen_done && c < 120) begin
            if (ready_v[o]) ready_bad = 1;
            if (valid_v[o]) begin
                chk(idx_v[o] == 2'(nexp), rq, "beat index (R7)", 128'(idx_v[o]), 128'(nexp));
                for (int k = 0; k < bw; k++) begin
                    chk(data_v[o][k*32 +: 32] == ref_word(base + 16'(nexp + k)),
                        rq, "word data (R8)", 128'(data_v[o][k*32 +: 32]),
                        128'(ref_word(base + 16'(nexp + k))));
                end
                if (nexp == 0) chk(c == 17, "R2", "first beat cycle", 128'(c), 128'd17);
                if (nexp + bw == 4) chk(c == lat, rq, "last beat cycle", 128'(c), 128'(lat));
                nexp += bw;
            end
            if (done_v[o]) begin
                seen_done = 1;
                chk(c == lat + 1, "R10", "done cycle", 128'(c), 128'(lat + 1));
                chk(nexp == 4, rq, "words delivered", 128'(nexp), 128'd4);
                req_v[o] = 1'b0;
            end else begin
                @(negedge clk);
                c++;
            end
        end
        chk(seen_done, "R10", "done seen", 128'(seen_done), 128'd1);
        chk(!ready_bad, "R9", "ready low during fill", 128'(ready_bad), 128'd0);
        @(negedge clk);
        chk(ready_v[o] && !valid_v[o] && !done_v[o], "R10", "idle after done",
            {125'b0, ready_v[o], valid_v[o], done_v[o]}, 128'b100);
    endtask

    task automatic t_reset;
        for (int o = 0; o < 4; o++) begin
            chk(ready_v[o] && !valid_v[o] && !done_v[o], "R1", "reset state",
                {125'b0, ready_v[o], valid_v[o], done_v[o]}, 128'b100);
        end
    endtask

    task automatic t_narrow;   run_fill(1, 16'h0044, 65, 0, "R3"); endtask
    task automatic t_dual;     run_fill(2, 16'h1238, 33, 0, "R4"); endtask
    task automatic t_quad;     run_fill(3, 16'hBEEC, 17, 0, "R5"); endtask
    task automatic t_intlv;    run_fill(0, 16'h0120, 20, 0, "R6"); endtask
    task automatic t_unalign;  run_fill(0, 16'h00F7, 20, 0, "R7"); endtask
    task automatic t_held_req; run_fill(0, 16'h7A5D, 20, 1, "R9"); endtask
    task automatic t_held_dual; run_fill(2, 16'h0003, 33, 1, "R9"); endtask

    initial begin
        for (int o = 0; o < 4; o++) begin
            req_v[o]  = 1'b0;
            addr_v[o] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_narrow();
        t_dual();
        t_quad();
        t_intlv();
        t_unalign();
        t_held_req();
        t_held_dual();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule